// File: doc/BRIEF.md
# Indirect PHY Register Access Bridge

This block lets a host reach an 8-bit PHY configuration register space through only two host-visible registers: a command/address register and a data register. To write a PHY register, the host first loads the data register and then writes the command register with the target offset and the write flag set. To read one, the host writes the command register with the write flag clear. In both cases the host then polls a busy flag in the command register until the transfer has finished. After a read, the byte that was fetched sits in the data register.

On the PHY side the bridge issues a single request and holds it until a variable-latency target answers with a one-cycle acknowledge. Read data is captured on that acknowledge. The host bus is a plain register interface with separate write and read strobes. Reads are combinational from the current offset and strobe.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset, the command register (offset 0x300) and the data register (offset 0x304) both read 0x0000, and phy_req is low.
- R2: A host write to 0x300 while idle starts a PHY transfer. On the next cycle phy_req is high, phy_addr equals bits [7:0] of the written value, and phy_we equals bit 8 (1 means write, 0 means read). For a write, phy_wdata equals bits [7:0] of the data register.
- R3: Bit 9 of the command register reads 1 from the cycle after a command is accepted until the acknowledge edge. It reads 0 from the cycle after that edge.
- R4: When a read completes, the data register holds the acknowledged byte in bits [7:0] and zero in bits [15:8].
- R5: phy_req stays high, with phy_addr, phy_we and phy_wdata stable, until phy_ack is seen high. It drops in the cycle after that.
- R6: A write to 0x300 while busy is ignored. The running transfer continues unchanged, and no further transfer follows.
- R7: A write to 0x304 while busy is ignored. The data register keeps its contents.
- R8: Reading 0x300 returns the offset of the last accepted command in bits [7:0] and its direction in bit 8. Bits [15:10] read 0.
- R9: Host writes to any other offset have no effect, and host reads of any other offset return 0x0000.
- R10: A PHY write transfer leaves the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 12 | Host register offset |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data, zero unless host_rd |
| phy_req | output | 1 | PHY transfer request |
| phy_we | output | 1 | PHY transfer is a write |
| phy_addr | output | 8 | PHY register offset |
| phy_wdata | output | 8 | PHY write byte |
| phy_ack | input | 1 | One-cycle acknowledge from the PHY target |
| phy_rdata | input | 8 | PHY read byte, valid with phy_ack |

## Verification
The hardest case to reach from the ports is a new command or data write that lands while a transfer is still waiting for its acknowledge. To create it, the bench stretches the behavioural target's latency to ten cycles. It then issues a second command and a data write back to back behind the first command. The scoreboard confirms that only the first transfer reaches the PHY and that it carries the original offset and byte. Later readbacks of the two registers and of the PHY memory confirm that nothing else changed.

// File: rtl/phy_bridge_pkg.sv
// Shared types for the indirect PHY register bridge.
// Assumes: a single outstanding PHY transfer at a time.
package phy_bridge_pkg;

    typedef enum logic {
        BR_IDLE = 1'b0,
        BR_WAIT = 1'b1
    } br_state_e;

endpackage

// File: rtl/bridge_host_regs.sv
// Host-facing register pair of the PHY bridge: the command/address register
// and the data register. Decodes host writes, launches transfers, captures
// read data on completion and serves host reads.
// Assumes: busy comes from the PHY controller, and done pulses for one cycle
// on the acknowledge edge.
module bridge_host_regs #(
    parameter int          HOST_AW  = 12,
    parameter int          HOST_DW  = 16,
    parameter int          PHY_AW   = 8,
    parameter int          PHY_DW   = 8,
    parameter logic [11:0] CMD_OFF  = 12'h300,
    parameter logic [11:0] DATA_OFF = 12'h304
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    input  logic               busy,
    input  logic               done,
    input  logic [PHY_DW-1:0]  phy_rdata,
    output logic               start,
    output logic [PHY_AW-1:0]  cmd_addr,
    output logic               cmd_we,
    output logic [PHY_DW-1:0]  cmd_wdata,
    output logic [HOST_DW-1:0] data_reg
);

    localparam int WR_BIT   = PHY_AW;
    localparam int BUSY_BIT = PHY_AW + 1;
    localparam int PAD_W    = HOST_DW - PHY_DW;

    logic              sel_cmd;
    logic              sel_data;
    logic [PHY_AW-1:0] addr_q;
    logic              we_q;
    logic [HOST_DW-1:0] data_q;

    // Purpose: decode which host register is addressed.
    always_comb begin
        sel_cmd  = (host_addr == CMD_OFF[HOST_AW-1:0]);
        sel_data = (host_addr == DATA_OFF[HOST_AW-1:0]);
    end

    assign start = host_wr && sel_cmd && !busy;

    // Purpose: hold the latched command offset and direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            we_q   <= 1'b0;
        end else if (start) begin
            addr_q <= host_wdata[PHY_AW-1:0];
            we_q   <= host_wdata[WR_BIT];
        end
    end

    // Purpose: update the data register from the host or from a finished read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (host_wr && sel_data && !busy) begin
            data_q <= host_wdata;
        end else if (done && !we_q) begin
            data_q <= {{PAD_W{1'b0}}, phy_rdata};
        end
    end

    // Purpose: return the addressed register for a host read.
    always_comb begin
        host_rdata = '0;
        if (host_rd) begin
            if (sel_cmd) begin
                host_rdata[PHY_AW-1:0] = addr_q;
                host_rdata[WR_BIT]     = we_q;
                host_rdata[BUSY_BIT]   = busy;
            end else if (sel_data) begin
                host_rdata = data_q;
            end
        end
    end

    assign cmd_addr  = addr_q;
    assign cmd_we    = we_q;
    assign cmd_wdata = data_q[PHY_DW-1:0];
    assign data_reg  = data_q;

endmodule

// File: rtl/bridge_phy_ctrl.sv
// PHY-side handshake controller: raises a request on start and holds it
// until the target acknowledges. While the request is open it reports busy.
// Assumes: phy_ack is a one-cycle pulse given only while a request is open.
module bridge_phy_ctrl
    import phy_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic phy_ack,
    output logic phy_req,
    output logic busy,
    output logic done
);

    br_state_e state_q;

    // Purpose: move between idle and waiting-for-acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BR_IDLE;
        end else begin
            case (state_q)
                BR_IDLE: if (start)   state_q <= BR_WAIT;
                BR_WAIT: if (phy_ack) state_q <= BR_IDLE;
                default:              state_q <= BR_IDLE;
            endcase
        end
    end

    // Purpose: derive the request, busy and completion strobes from the state.
    always_comb begin
        phy_req = (state_q == BR_WAIT);
        busy    = phy_req;
        done    = phy_req && phy_ack;
    end

endmodule

// File: rtl/phy_reg_bridge.sv
// Top of the indirect PHY register bridge. A host command write selects a
// PHY register and starts one request/acknowledge transfer. The host polls
// the busy bit in the same register for completion.
// Assumes: host strobes last one cycle each.
module phy_reg_bridge #(
    parameter int          HOST_AW  = 12,
    parameter int          HOST_DW  = 16,
    parameter int          PHY_AW   = 8,
    parameter int          PHY_DW   = 8,
    parameter logic [11:0] CMD_OFF  = 12'h300,
    parameter logic [11:0] DATA_OFF = 12'h304
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               phy_req,
    output logic               phy_we,
    output logic [PHY_AW-1:0]  phy_addr,
    output logic [PHY_DW-1:0]  phy_wdata,
    input  logic               phy_ack,
    input  logic [PHY_DW-1:0]  phy_rdata
);

    logic               start;
    logic               busy;
    logic               done;
    logic [HOST_DW-1:0] data_reg;

    bridge_host_regs #(
        .HOST_AW (HOST_AW),
        .HOST_DW (HOST_DW),
        .PHY_AW  (PHY_AW),
        .PHY_DW  (PHY_DW),
        .CMD_OFF (CMD_OFF),
        .DATA_OFF(DATA_OFF)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .host_addr (host_addr),
        .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .busy      (busy),
        .done      (done),
        .phy_rdata (phy_rdata),
        .start     (start),
        .cmd_addr  (phy_addr),
        .cmd_we    (phy_we),
        .cmd_wdata (phy_wdata),
        .data_reg  (data_reg)
    );

    bridge_phy_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .phy_ack(phy_ack),
        .phy_req(phy_req),
        .busy   (busy),
        .done   (done)
    );

endmodule

// File: rtl/phy_reg_bridge_chk.sv
// Protocol checker for phy_reg_bridge, attached by bind.
// Assumes: the default 8-bit PHY offset and byte widths.
module phy_reg_bridge_chk #(
    parameter int          HOST_AW  = 12,
    parameter int          HOST_DW  = 16,
    parameter int          PHY_AW   = 8,
    parameter int          PHY_DW   = 8,
    parameter logic [11:0] CMD_OFF  = 12'h300
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_wr,
    input logic [HOST_AW-1:0] host_addr,
    input logic [HOST_DW-1:0] host_wdata,
    input logic               phy_req,
    input logic               phy_we,
    input logic [PHY_AW-1:0]  phy_addr,
    input logic [PHY_DW-1:0]  phy_wdata,
    input logic               phy_ack,
    input logic [PHY_DW-1:0]  phy_rdata,
    input logic [HOST_DW-1:0] data_reg
);

    localparam int PAD_W = HOST_DW - PHY_DW;

    AST_CMD_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == CMD_OFF[HOST_AW-1:0] && !phy_req)
        |=> (phy_req && phy_addr == $past(host_wdata[PHY_AW-1:0])
             && phy_we == $past(host_wdata[PHY_AW]))); // R2

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_ack)
        |=> (phy_req && $stable(phy_addr) && $stable(phy_we)
             && $stable(phy_wdata))); // R5

    AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_ack) |=> !phy_req); // R5

    AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_ack && !phy_we)
        |=> (data_reg == {{PAD_W{1'b0}}, $past(phy_rdata)})); // R4

    AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && !phy_ack) |=> $stable(data_reg)); // R7

    AST_WRITE_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_req && phy_ack && phy_we) |=> $stable(data_reg)); // R10

endmodule

bind phy_reg_bridge phy_reg_bridge_chk #(
    .HOST_AW(HOST_AW),
    .HOST_DW(HOST_DW),
    .PHY_AW (PHY_AW),
    .PHY_DW (PHY_DW),
    .CMD_OFF(CMD_OFF)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .phy_req   (phy_req),
    .phy_we    (phy_we),
    .phy_addr  (phy_addr),
    .phy_wdata (phy_wdata),
    .phy_ack   (phy_ack),
    .phy_rdata (phy_rdata),
    .data_reg  (data_reg)
);

// File: tb/sim_phy_reg_bridge.sv
module sim_phy_reg_bridge;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [11:0] host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        phy_req;
    logic        phy_we;
    logic [7:0]  phy_addr;
    logic [7:0]  phy_wdata;
    logic        phy_ack = 1'b0;
    logic [7:0]  phy_rdata = '0;

    int checks = 0;
    int fails  = 0;
    int txn_seen = 0;
    int lat = 0;
    int cnt = 0;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic [16:0] exp_q [$];

    always #2 clk = ~clk;

    phy_reg_bridge u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr),
        .phy_wdata(phy_wdata), .phy_ack(phy_ack), .phy_rdata(phy_rdata)
    );

    // Behavioural PHY register target with programmable latency.
    always @(posedge clk) begin
        if (!rst_n) begin
            phy_ack <= 1'b0;
            cnt     <= 0;
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
        end else if (phy_ack) begin
            phy_ack <= 1'b0;
            cnt     <= 0;
        end else if (phy_req) begin
            if (cnt >= lat) begin
                phy_ack <= 1'b1;
                if (phy_we) mem[phy_addr] <= phy_wdata;
                phy_rdata <= mem[phy_addr];
            end else begin
                cnt <= cnt + 1;
            end
        end else begin
            cnt <= 0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop expected PHY transfers and compare; check request stability.
    logic       p_req = 1'b0, p_ack = 1'b0, p_we = 1'b0;
    logic [7:0] p_addr = '0, p_wd = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_req && !p_ack)
                check(phy_req && phy_addr == p_addr && phy_we == p_we && phy_wdata == p_wd,
                      "R5 hold", {phy_req, phy_we, phy_addr, phy_wdata}, {1'b1, p_we, p_addr, p_wd});
            if (p_req && p_ack)
                check(!phy_req, "R5 release", phy_req, 0);
            if (phy_req && phy_ack) begin
                txn_seen++;
                if (exp_q.size() == 0) begin
                    check(0, "R6 unexpected transfer", {phy_we, phy_addr}, 0);
                end else begin
                    logic [16:0] e;
                    logic [16:0] a;
                    e = exp_q.pop_front();
                    a = {phy_we, phy_addr, phy_we ? phy_wdata : 8'h00};
                    check(a == e, "R2 transfer", a, e);
                end
            end
            p_req = phy_req; p_ack = phy_ack; p_we = phy_we;
            p_addr = phy_addr; p_wd = phy_wdata;
        end
    end

    task automatic hwrite(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [11:0] a, output logic [15:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        host_rd = 1'b0;
    endtask

    task automatic wait_idle(output int polls);
        logic [15:0] v;
        polls = 0;
        v = 16'h0200;
        while (v[9] && polls < 200) begin
            hread(12'h300, v);
            polls++;
        end
        check(!v[9], "R3 busy clears", v, 0);
    endtask

    // Driver: issue a PHY write or read and push the expected transfer.
    task automatic phy_write(input logic [7:0] a, input logic [7:0] d);
        int p;
        hwrite(12'h304, {8'h00, d});
        exp_q.push_back({1'b1, a, d});
        exp_mem[a] = d;
        hwrite(12'h300, {7'h00, 1'b1, a});
        wait_idle(p);
    endtask

    task automatic phy_read(input logic [7:0] a);
        int p;
        logic [15:0] v;
        exp_q.push_back({1'b0, a, 8'h00});
        hwrite(12'h300, {7'h00, 1'b0, a});
        wait_idle(p);
        hread(12'h304, v);
        check(v == {8'h00, exp_mem[a]}, "R4 read data", v, {8'h00, exp_mem[a]});
    endtask

    initial begin
        logic [15:0] v;
        int p;
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i * 7 + 3);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        hread(12'h300, v); check(v == 16'h0000, "R1 cmd reg", v, 0);
        hread(12'h304, v); check(v == 16'h0000, "R1 data reg", v, 0);
        check(!phy_req, "R1 req low", phy_req, 0);

        // R2, R3, R8, R10: write with latency 3, busy visible right after
        lat = 3;
        hwrite(12'h304, 16'hAB12);
        exp_q.push_back({1'b1, 8'h3C, 8'h12});
        exp_mem[8'h3C] = 8'h12;
        hwrite(12'h300, 16'h013C);
        hread(12'h300, v);
        check(v == 16'h033C, "R3 busy set / R8 readback", v, 16'h033C);
        wait_idle(p);
        check(p >= 2, "R3 busy lasts", p, 2);
        hread(12'h300, v); check(v == 16'h013C, "R8 cmd after write", v, 16'h013C);
        hread(12'h304, v); check(v == 16'hAB12, "R10 data kept", v, 16'hAB12);

        // R4: read back with several latencies
        lat = 0; phy_read(8'h3C);
        hread(12'h300, v); check(v == 16'h003C, "R8 cmd after read", v, 16'h003C);
        lat = 7; phy_read(8'hFF);
        lat = 1; phy_write(8'h00, 8'hC3); phy_read(8'h00);
        lat = 2; phy_write(8'h80, 8'h5A); phy_read(8'h80); phy_read(8'h7F);

        // R6, R7: command and data writes while busy
        lat = 10;
        hwrite(12'h304, 16'h0055);
        exp_q.push_back({1'b1, 8'h40, 8'h55});
        exp_mem[8'h40] = 8'h55;
        hwrite(12'h300, 16'h0140);
        hwrite(12'h300, 16'h0041);
        hwrite(12'h304, 16'h00EE);
        wait_idle(p);
        hread(12'h300, v); check(v == 16'h0140, "R6 cmd ignored", v, 16'h0140);
        hread(12'h304, v); check(v == 16'h0055, "R7 data ignored", v, 16'h0055);
        lat = 0;
        phy_read(8'h40);
        phy_read(8'h41);

        // R9: other offsets
        hwrite(12'h302, 16'hFFFF);
        hwrite(12'h308, 16'h0111);
        hread(12'h302, v); check(v == 16'h0000, "R9 unmapped read", v, 0);
        hread(12'h300, v); check(v == 16'h0041, "R9 cmd untouched", v, 16'h0041);
        hread(12'h304, v); check(v == {8'h00, exp_mem[8'h41]}, "R9 data untouched", v, exp_mem[8'h41]);
        repeat (4) @(negedge clk);
        check(!phy_req, "R9 no transfer", phy_req, 0);

        check(exp_q.size() == 0, "R6 all transfers seen", exp_q.size(), 0);
        check(txn_seen == 11, "R6 transfer count", txn_seen, 11);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule